// File: doc/BRIEF.md
# Interrupt Coalescing Controller

This block decides, for a single interrupt vector, when the status block in host memory should be refreshed and when the interrupt line should be raised. It counts completed receive and transmit descriptors, and the tick strobes seen while completions are pending. When a count or a tick limit is met, it raises a request to the status-block writer and holds it until that writer acknowledges. The acknowledge restarts all accumulation.

Once the host writes a nonzero value to the mailbox, the block enters a masked phase. In that phase the interrupt stays low and a second pair of descriptor-count limits applies. A limit met during the masked phase still refreshes the status block. A zero mailbox write ends the masked phase.

Limits are held in 17 sets of six. Set 0 serves when all rings share one vector. The set chosen by the `VEC_ID` parameter serves in per-vector mode.

Top module: `irq_coalescer`

## Requirements
- R1: With a receive count limit L (field 2) above zero and the block unmasked, the update request rises the cycle after the L-th receive completion has been counted. The interrupt rises in that same cycle and stays high until the host writes a nonzero mailbox value.
- R2: With a receive tick limit T (field 0) or transmit tick limit T (field 1) above zero, a request fires once T ticks have been counted while completions of that direction are pending, even if no count limit fires. Ticks seen while nothing is pending are not counted.
- R3: A transmit count limit of 1 (field 3) yields one update request for every transmit completion.
- R4: A mailbox write with a nonzero value enters the masked phase and drops the interrupt on the next cycle.
- R5: In the masked phase, the receive count limit is field 4 and the transmit count limit is field 5, in place of fields 2 and 3.
- R6: A request raised in the masked phase leaves the interrupt low.
- R7: An acknowledged update clears both the receive and the transmit pending counts, whichever direction caused it.
- R8: The active set is set 0 when per_vector is low and set VEC_ID when it is high. The set is given by cfg_set, and the field within it by cfg_sel (0 to 5).
- R9: A limit of 0 disables its trigger.
- R10: At most one request is outstanding. Triggers seen while a request is outstanding merge into it and do not cause a second request after the acknowledge.
- R11: A completion that arrives in the acknowledge cycle counts towards the next update.
- R12: A zero mailbox write in the masked phase ends it. If completions are pending at that moment, a request and the interrupt rise on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_done | input | 1 | One receive descriptor completed |
| tx_done | input | 1 | One transmit descriptor completed |
| tick | input | 1 | Free-running tick strobe |
| mbox_we | input | 1 | Host mailbox write strobe |
| mbox_data | input | MBOX_W | Host mailbox write value |
| cfg_we | input | 1 | Limit register write strobe |
| cfg_set | input | SET_W | Limit set index |
| cfg_sel | input | 3 | Field within set (0 rx ticks, 1 tx ticks, 2 rx count, 3 tx count, 4 rx count masked, 5 tx count masked) |
| cfg_data | input | CNT_W | Limit value |
| per_vector | input | 1 | Selects set VEC_ID instead of set 0 |
| upd_ack | input | 1 | Status-block writer acknowledge |
| upd_req | output | 1 | Status-block update request |
| irq | output | 1 | Interrupt line |

## Verification
The assertions check on every cycle that:
- an outstanding request holds until it is acknowledged;
- the interrupt is never high in the masked phase;
- a nonzero mailbox write masks the interrupt;
- an acknowledge empties the counts while keeping any completion that arrives alongside it;
- a transmit limit of 1 fires after each descriptor.

Only the bench scenarios show the exact descriptor and tick counts at which each trigger fires. The same holds for the choice between normal and masked limits, parameter-set selection, disabling by zero, and the re-arm when the masked phase ends with work still pending.

// File: rtl/irq_coalescer.sv
module irq_coalescer #(
  parameter int NSETS  = 17,
  parameter int VEC_ID = 1,
  parameter int CNT_W  = 8,
  parameter int MBOX_W = 32,
  parameter int SET_W  = $clog2(NSETS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_done,
  input  logic              tx_done,
  input  logic              tick,
  input  logic              mbox_we,
  input  logic [MBOX_W-1:0] mbox_data,
  input  logic              cfg_we,
  input  logic [SET_W-1:0]  cfg_set,
  input  logic [2:0]        cfg_sel,
  input  logic [CNT_W-1:0]  cfg_data,
  input  logic              per_vector,
  input  logic              upd_ack,
  output logic              upd_req,
  output logic              irq
);
  localparam int NREG  = NSETS * 6;
  localparam int IDX_W = $clog2(NREG);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [CNT_W-1:0] thr_q [NREG];
  logic [CNT_W-1:0] rx_cnt, tx_cnt, rx_tk, tx_tk;
  logic             in_di;

  logic [IDX_W-1:0] wr_idx, base;
  assign wr_idx = IDX_W'(int'(cfg_set) * 6 + int'(cfg_sel));
  assign base   = per_vector ? IDX_W'(VEC_ID * 6) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) thr_q[i] <= '0;
    end else if (cfg_we && int'(cfg_set) < NSETS && cfg_sel < 3'd6) begin
      thr_q[wr_idx] <= cfg_data;
    end
  end

  logic [CNT_W-1:0] t_rx_tk, t_tx_tk, t_rx_lim, t_tx_lim;
  assign t_rx_tk  = thr_q[base];
  assign t_tx_tk  = thr_q[base + IDX_W'(1)];
  assign t_rx_lim = in_di ? thr_q[base + IDX_W'(4)] : thr_q[base + IDX_W'(2)];
  assign t_tx_lim = in_di ? thr_q[base + IDX_W'(5)] : thr_q[base + IDX_W'(3)];

  logic rx_pend, tx_pend, hit, enter, leave, fire, done;
  assign rx_pend = rx_cnt != '0;
  assign tx_pend = tx_cnt != '0;
  assign hit = (t_rx_lim != '0 && rx_cnt >= t_rx_lim)
            || (t_tx_lim != '0 && tx_cnt >= t_tx_lim)
            || (t_rx_tk  != '0 && rx_pend && rx_tk >= t_rx_tk)
            || (t_tx_tk  != '0 && tx_pend && tx_tk >= t_tx_tk);
  assign enter = mbox_we && mbox_data != '0;
  assign leave = mbox_we && mbox_data == '0 && in_di;
  assign fire  = !upd_req && (hit || (leave && (rx_pend || tx_pend)));
  assign done  = upd_req && upd_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_cnt <= '0; tx_cnt <= '0; rx_tk <= '0; tx_tk <= '0;
    end else if (done) begin
      rx_cnt <= CNT_W'(rx_done);
      tx_cnt <= CNT_W'(tx_done);
      rx_tk  <= '0;
      tx_tk  <= '0;
    end else begin
      if (rx_done && rx_cnt != CMAX) rx_cnt <= rx_cnt + 1'b1;
      if (tx_done && tx_cnt != CMAX) tx_cnt <= tx_cnt + 1'b1;
      if (tick && rx_pend && rx_tk != CMAX) rx_tk <= rx_tk + 1'b1;
      if (tick && tx_pend && tx_tk != CMAX) tx_tk <= tx_tk + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upd_req <= 1'b0;
      in_di   <= 1'b0;
      irq     <= 1'b0;
    end else begin
      upd_req <= upd_req ? !upd_ack : fire;
      if (enter)      in_di <= 1'b1;
      else if (leave) in_di <= 1'b0;
      if (enter)                          irq <= 1'b0;
      else if (fire && (!in_di || leave)) irq <= 1'b1;
    end
  end

  assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    upd_req && !upd_ack |=> upd_req);
  assert_masked_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_di |-> !irq);
  assert_mbox_masks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    enter |=> in_di && !irq);
  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done && !rx_done && !tx_done |=> rx_cnt == '0 && tx_cnt == '0);
  assert_ack_keeps_event_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done && rx_done |=> rx_cnt == CNT_W'(1));
  assert_tx_every_R3: assert property (@(posedge clk) disable iff (!rst_n)
    thr_q[base + IDX_W'(3)] == CNT_W'(1) && !in_di && tx_pend && !upd_req |=> upd_req);
endmodule

// File: tb/irq_coalescer_bench.sv
module irq_coalescer_bench;
  localparam int SET_W = 5;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_done = 0, tx_done = 0, tick = 0, mbox_we = 0, cfg_we = 0, per_vector = 0, upd_ack = 0;
  logic [31:0] mbox_data = '0;
  logic [SET_W-1:0] cfg_set = '0;
  logic [2:0] cfg_sel = '0;
  logic [7:0] cfg_data = '0;
  logic upd_req, irq;
  int n_run = 0, n_fail = 0, cyc = 0;

  irq_coalescer u_irq_coalescer (.clk, .rst_n, .rx_done, .tx_done, .tick, .mbox_we, .mbox_data,
    .cfg_we, .cfg_set, .cfg_sel, .cfg_data, .per_vector, .upd_ack, .upd_req, .irq);

  always #5 clk = ~clk;

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired act=%0d exp<=50000", cyc);
      summary();
    end
  end

  task automatic step; @(negedge clk); endtask
  task automatic chk(string req, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0b exp=%0b at cycle %0d", req, act, exp, cyc);
    end
  endtask
  task automatic cfg(int s, int f, int v);
    cfg_we = 1; cfg_set = SET_W'(s); cfg_sel = 3'(f); cfg_data = 8'(v); step(); cfg_we = 0;
  endtask
  task automatic clear_sets;
    for (int f = 0; f < 6; f++) begin cfg(0, f, 0); cfg(1, f, 0); end
  endtask
  task automatic prx; rx_done = 1; step(); rx_done = 0; endtask
  task automatic ptx; tx_done = 1; step(); tx_done = 0; endtask
  task automatic ack; upd_ack = 1; step(); upd_ack = 0; endtask
  task automatic mbox(int v); mbox_we = 1; mbox_data = v; step(); mbox_we = 0; endtask
  task automatic host_done; mbox(1); mbox(0); endtask

  initial begin
    step(); step(); rst_n = 1; step();
    chk("R1 reset req", upd_req, 0);
    chk("R1 reset irq", irq, 0);

    for (int thr = 1; thr <= 6; thr++) begin
      clear_sets(); cfg(0, 2, thr);
      for (int k = 1; k <= thr; k++) begin prx(); chk("R1 rx below limit", upd_req, 0); end
      step(); chk("R1 rx limit req", upd_req, 1); chk("R1 rx limit irq", irq, 1);
      ack(); chk("R1 ack drops req", upd_req, 0);
      step(); chk("R10 no refire", upd_req, 0);
      mbox(1); chk("R4 nonzero masks irq", irq, 0);
      mbox(0); chk("R12 leave idle no req", upd_req, 0);
    end

    for (int thr = 2; thr <= 4; thr++) begin
      clear_sets(); cfg(0, 3, thr);
      for (int k = 1; k <= thr; k++) begin ptx(); chk("R1 tx below limit", upd_req, 0); end
      step(); chk("R1 tx limit req", upd_req, 1);
      ack(); host_done();
    end

    clear_sets(); cfg(0, 3, 1);
    for (int k = 0; k < 4; k++) begin
      ptx(); step(); chk("R3 tx every descriptor", upd_req, 1);
      ack(); step(); chk("R3 single req per descriptor", upd_req, 0);
    end
    host_done();

    for (int t = 1; t <= 4; t++) begin
      for (int d = 0; d < 2; d++) begin
        clear_sets(); cfg(0, d, t);
        for (int k = 0; k < 3 * t; k++) begin tick = 1; step(); end
        tick = 0; step(); chk("R2 ticks idle ignored", upd_req, 0);
        if (d == 0) prx(); else ptx();
        tick = 1;
        for (int k = 1; k <= t; k++) begin step(); chk("R2 before tick limit", upd_req, 0); end
        tick = 0; step(); chk("R2 tick limit fires", upd_req, 1);
        ack(); host_done();
      end
    end

    clear_sets(); cfg(0, 2, 4); cfg(0, 4, 2);
    mbox(7); chk("R4 masked irq low", irq, 0);
    prx(); prx(); step(); chk("R5 masked rx limit", upd_req, 1); chk("R6 irq stays low", irq, 0);
    ack(); prx(); step(); chk("R5 below masked limit", upd_req, 0);
    mbox(0); chk("R12 rearm req", upd_req, 1); chk("R12 rearm irq", irq, 1);
    ack(); host_done();

    clear_sets(); cfg(0, 3, 1);
    mbox(3); ptx(); ptx(); ptx(); step();
    chk("R9 masked tx limit zero", upd_req, 0);
    mbox(0); chk("R12 rearm on tx pending", upd_req, 1);
    ack(); host_done();

    clear_sets(); cfg(0, 2, 3); cfg(0, 3, 5);
    ptx(); ptx(); prx(); prx(); prx(); step(); chk("R7 rx fires", upd_req, 1);
    ack(); ptx(); ptx(); ptx(); step(); chk("R7 tx pending cleared", upd_req, 0);
    ptx(); ptx(); step(); chk("R7 tx fires from fresh count", upd_req, 1);
    ack(); host_done();

    clear_sets(); cfg(1, 2, 2); cfg(0, 2, 6);
    per_vector = 1; prx(); prx(); step(); chk("R8 vector set used", upd_req, 1);
    ack(); host_done();
    per_vector = 0; prx(); prx(); step(); chk("R8 set 0 not yet", upd_req, 0);
    for (int k = 0; k < 4; k++) prx();
    step(); chk("R8 set 0 limit", upd_req, 1);
    ack(); host_done();

    clear_sets();
    for (int k = 0; k < 20; k++) begin rx_done = 1; tx_done = 1; tick = 1; step(); end
    rx_done = 0; tx_done = 0; tick = 0; step();
    chk("R9 all limits zero", upd_req, 0);
    chk("R9 irq low", irq, 0);
    cfg(0, 2, 1); step(); chk("R9 pending kept", upd_req, 1);
    ack(); host_done();

    clear_sets(); cfg(0, 2, 1);
    prx(); step(); chk("R10 req raised", upd_req, 1);
    for (int k = 0; k < 3; k++) begin prx(); chk("R10 merged held", upd_req, 1); end
    rx_done = 1; upd_ack = 1; step(); rx_done = 0; upd_ack = 0;
    chk("R10 ack drops", upd_req, 0);
    step(); chk("R11 ack cycle event counted", upd_req, 1);
    ack(); step(); chk("R10 no extra request", upd_req, 0);
    host_done();

    summary();
  end
endmodule